// File: doc/BRIEF.md
# Radix-2 delay-commutator stage with shared add/subtract

This block is the front end of one stage in a single-path pipelined radix-2 FFT. Samples arrive as real words, one per cycle, with each complex sample sent as its real part and then its imaginary part. A `valid_i` strobe qualifies each word.

The stage pairs samples whose indices are `N_PTS/2^STAGE` apart. A circular delay buffer reorders the word stream so that the two operands of each butterfly sit in adjacent slots. The real parts of a pair come first, then their imaginary parts. One real adder and one real subtractor turn each operand couple into a sum and a difference. The sum takes the slot of the earlier-index operand and the difference takes the slot of the later one, so the word order of the stream is kept.

The outputs either grow by one bit or are halved, as chosen by the `HALVE` parameter. The whole pipeline advances only on valid words, so gaps in the input stream do not change the results. Twiddle multiplication is left to a following unit.

Top module: `sdc_bfly_stage`

## Requirements
- R1: `data_o` and `valid_o` change only in the cycle after a word is accepted. After a cycle with `valid_i` low, `valid_o` is 0 and `data_o` keeps its value.
- R2: With D = `N_PTS >> STAGE`, the input word stream is handled in blocks of 4D words. Word q of the first half of a block (q < 2D) is paired with word q+2D of the same block, so sample k is paired with sample k+D.
- R3: Results leave in couple order. For a couple (a, b), the sum word comes first and the difference word comes next. Couples follow in the order of q, so the real-part couple of a sample pair precedes its imaginary-part couple.
- R4: With `HALVE`=0, the sum word is a+b and the difference word is a−b, where a is the word from the first half of the block.
- R5: With `HALVE`=0, `data_o` is `IN_W`+1 bits wide and represents every sum and difference of full-scale inputs exactly, from −2^IN_W to 2^IN_W−1.
- R6: With `HALVE`=1, `data_o` is `IN_W` bits wide and carries floor((a±b)/2).
- R7: Result word i leaves, with `valid_o` high, in the cycle after input word i+2D+1 is accepted (counting from 0). `valid_o` stays low for the first 2D+1 accepted words.
- R8: Idle cycles anywhere in the input stream leave the sequence of output words unchanged.
- R9: While `rst_ni` is low, `valid_o` is 0 and `data_o` is 0.
- R10: Back-to-back blocks are processed without any idle cycles, and each block pairs only its own words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `data_i` |
| data_i | input | IN_W | Signed input word (real or imaginary part) |
| valid_o | output | 1 | Qualifies `data_o` |
| data_o | output | IN_W+1−HALVE | Signed sum or difference word |

## Verification
Properties check on every cycle that the outputs move only after accepted words and hold otherwise. They also check that no result leaves before the commutator has filled, and that the couple phase alternates with every accepted word. The pairing distance, the sum-then-difference order, exact full-scale growth, halving, behaviour across block boundaries and independence from idle cycles can only be shown by the bench. It runs ramp, full-scale and gapped random streams through two stage configurations and compares every output word against a butterfly model.

// File: rtl/sdc_bfly_pkg.sv
package sdc_bfly_pkg;
  // words held between a first-half operand and its partner
  function automatic int span_words(input int n_pts, input int stage);
    return 2 * (n_pts >> stage);
  endfunction

  typedef enum logic {SLOT_FIRST = 1'b0, SLOT_SECOND = 1'b1} slot_e;
endpackage

// File: rtl/sdc_commutator.sv
module sdc_commutator
  import sdc_bfly_pkg::*;
#(
  parameter int N_PTS = 16,
  parameter int STAGE = 1,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          op_vld_o,
  output slot_e         op_slot_o,
  output logic [DW-1:0] op_o
);
  localparam int SPAN  = span_words(N_PTS, STAGE);
  localparam int DEPTH = 2 * SPAN;
  localparam int AW    = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, fill_q, rpos, raddr;

  // position in the reordered stream, one span behind the writer
  assign rpos  = {~wptr_q[AW-1], wptr_q[AW-2:0]};
  assign raddr = {rpos[0], rpos[AW-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (valid_i) begin
      wptr_q <= wptr_q + 1'b1;
      if (fill_q != AW'(SPAN)) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) mem_q[wptr_q] <= data_i;
  end

  assign op_o      = mem_q[raddr];
  assign op_slot_o = slot_e'(rpos[0]);
  assign op_vld_o  = valid_i && (fill_q == AW'(SPAN));

  // R2
  operand_not_overwritten_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (raddr != wptr_q));

  // R3
  slot_alternates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (rpos[0] != $past(rpos[0])));
endmodule

// File: rtl/sdc_addsub.sv
module sdc_addsub
  import sdc_bfly_pkg::*;
#(
  parameter int DW    = 16,
  parameter int HALVE = 0,
  parameter int OW    = DW + 1 - HALVE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          op_vld_i,
  input  slot_e         slot_i,
  input  logic [DW-1:0] op_i,
  output logic          valid_o,
  output logic [OW-1:0] data_o
);
  logic [DW-1:0] first_q;
  logic [OW-1:0] diff_q, data_q, sum_sc, diff_sc;
  logic          primed_q, valid_q;
  logic [DW:0]   sum_w, diff_w;

  assign sum_w  = {first_q[DW-1], first_q} + {op_i[DW-1], op_i};
  assign diff_w = {first_q[DW-1], first_q} - {op_i[DW-1], op_i};

  if (HALVE != 0) begin : g_halve
    assign sum_sc  = sum_w[DW:1];
    assign diff_sc = diff_w[DW:1];
  end else begin : g_grow
    assign sum_sc  = sum_w;
    assign diff_sc = diff_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      diff_q   <= '0;
      data_q   <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= en_i && op_vld_i && (slot_i == SLOT_SECOND || primed_q);
      if (en_i && op_vld_i) begin
        if (slot_i == SLOT_SECOND) begin
          data_q   <= sum_sc;
          diff_q   <= diff_sc;
          primed_q <= 1'b1;
        end else begin
          first_q <= op_i;
          data_q  <= diff_q;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R1
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!valid_o && $stable(data_o)));

  // R3
  sum_emitted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_vld_i && slot_i == SLOT_SECOND) |=> valid_o);

  // R7
  primed_before_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> primed_q);
endmodule

// File: rtl/sdc_bfly_stage.sv
module sdc_bfly_stage
  import sdc_bfly_pkg::*;
#(
  parameter int N_PTS = 16,
  parameter int STAGE = 1,
  parameter int IN_W  = 16,
  parameter int HALVE = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [IN_W-1:0]       data_i,
  output logic                  valid_o,
  output logic [IN_W-HALVE:0]   data_o
);
  localparam int OUT_W = IN_W + 1 - HALVE;
  localparam int LAT   = span_words(N_PTS, STAGE) + 1;
  localparam int CW    = $clog2(LAT + 2) + 1;

  logic            op_vld;
  slot_e           op_slot;
  logic [IN_W-1:0] op;

  sdc_commutator #(.N_PTS(N_PTS), .STAGE(STAGE), .DW(IN_W)) u_comm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .op_vld_o (op_vld),
    .op_slot_o(op_slot),
    .op_o     (op)
  );

  sdc_addsub #(.DW(IN_W), .HALVE(HALVE), .OW(OUT_W)) u_as (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (valid_i),
    .op_vld_i(op_vld),
    .slot_i  (op_slot),
    .op_i    (op),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  // accepted-word counter used only by the checks below
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (valid_i && seen_q <= CW'(LAT)) seen_q <= seen_q + 1'b1;
  end

  // R7
  no_early_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (seen_q > CW'(LAT)));

  // R1
  output_follows_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
endmodule

// File: tb/sim_sdc_bfly_stage.sv
`timescale 1ns/1ps
module sim_sdc_bfly_stage;
  localparam int N_PTS = 16;
  localparam int IN_W  = 16;
  localparam int D0 = N_PTS >> 1;
  localparam int D1 = N_PTS >> 2;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [IN_W-1:0] data_i = '0;
  logic v0, v1;
  logic [IN_W:0]   d0;
  logic [IN_W-1:0] d1;

  always #2 clk = ~clk;

  sdc_bfly_stage #(.N_PTS(N_PTS), .STAGE(1), .IN_W(IN_W), .HALVE(0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(v0), .data_o(d0));

  sdc_bfly_stage #(.N_PTS(N_PTS), .STAGE(2), .IN_W(IN_W), .HALVE(1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(v1), .data_o(d1));

  int checks = 0, errors = 0;
  int in_mem [512];
  int nw = 0;
  bit prev_v = 0;
  int prev_n = 0;
  string prev_tag = "R4";
  int last0 = 0, last1 = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (word %0d)", tag, act, exp, prev_n);
    end
  endtask

  function automatic int expect_word(int i, int dd, bit halve);
    int q, blk, qp, a, b, s;
    q   = i / 2;
    blk = q / (2 * dd);
    qp  = q % (2 * dd);
    a   = in_mem[blk * 4 * dd + qp];
    b   = in_mem[blk * 4 * dd + 2 * dd + qp];
    s   = (i % 2 == 0) ? a + b : a - b;
    if (halve) s = s >>> 1;
    return s;
  endfunction

  task automatic check_prev();
    int a0, a1;
    a0 = int'($signed(d0));
    a1 = int'($signed(d1));
    if (prev_v) begin
      check("R7", int'(v0), int'(prev_n >= 2 * D0 + 1));
      check("R7", int'(v1), int'(prev_n >= 2 * D1 + 1));
      if (prev_n >= 2 * D0 + 1) check(prev_tag, a0, expect_word(prev_n - 2 * D0 - 1, D0, 1'b0));
      if (prev_n >= 2 * D1 + 1) check("R6", a1, expect_word(prev_n - 2 * D1 - 1, D1, 1'b1));
    end else begin
      check("R1", int'(v0), 0);
      check("R1", int'(v1), 0);
      check("R1", a0, last0);
      check("R1", a1, last1);
    end
    last0 = a0;
    last1 = a1;
  endtask

  task automatic cycle(bit v, int d, string tag);
    @(negedge clk);
    check_prev();
    valid_i = v;
    data_i  = IN_W'(d);
    prev_v  = v;
    prev_n  = nw;
    prev_tag = tag;
    if (v) begin
      in_mem[nw] = d;
      nw++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", int'(v0), 0);
    check("R9", int'(v1), 0);
    check("R9", int'($signed(d0)), 0);
    check("R9", int'($signed(d1)), 0);
    rst_ni = 1'b1;

    // R2/R3/R4/R10: continuous ramp over several blocks
    for (int k = 0; k < 64; k++) cycle(1'b1, k * 37 - 1000, "R2/R3/R4/R10");

    // R5: full-scale operands
    for (int k = 0; k < 64; k++) begin
      int sel;
      sel = (k >> 4) % 4;
      cycle(1'b1, (sel == 0) ? 32767 : -32768, "R5");
    end

    // R8: random data with idle gaps
    begin
      int seed_dummy;
      seed_dummy = $urandom(7);
      for (int k = 0; k < 128; k++) begin
        while ($urandom % 3 == 0) cycle(1'b0, 0, "R8");
        cycle(1'b1, int'($signed(16'($urandom))), "R8");
      end
    end

    for (int k = 0; k < 4; k++) cycle(1'b0, 0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule